// File: doc/BRIEF.md
# Double-buffered UART transmitter

This block sends characters on an asynchronous serial line. A holding register sits in front of the transmit shift register. Software can place the next character in the holding register while the current one is still leaving on the line. Frames carry eight data bits, or nine when a control field selects the longer format. In that case the ninth bit's value comes from a second control field. A free-running divider, programmed through a divisor input, sets the bit period.

Two flags report progress. The holding-empty flag is the interrupt source: it drops on every character write and rises when the holding register hands its character to the shifter. The shifter-empty flag is high only while no frame is on the line. The transfer rules are exact, so a write that lands on a baud tick at either edge of the stop bit produces exactly one copy of the new character.

Top module: `txq_uart`

## Requirements
- R1: While reset is held and just after it is released, the line is high, the holding-empty flag is 1 and the shifter-empty flag is 1.
- R2: A frame is one low start bit, then DATA_W data bits least significant first, then one high stop bit. Each bit lasts baud_div+1 clock cycles. The line changes only one cycle after a baud tick, and it stays high whenever no frame is in progress.
- R3: Writing the control address (wr_addr=1) sets the frame format: wr_data bit 0 set selects 9-bit frames, and wr_data bit 1 is the ninth bit. The ninth bit follows the last data bit. Both fields are captured when a character moves into the shifter.
- R4: A character written while the shifter is empty moves into it on the next baud tick. The start bit, the rising holding-empty flag and the falling shifter-empty flag all appear in the cycle after that tick.
- R5: A character that is waiting while a frame is on the line moves into the shifter on the tick that begins that frame's stop bit. The holding-empty flag rises in the same cycle that the stop bit appears.
- R6: If a character is waiting, or has already moved into the shifter, when the stop bit ends, its start bit follows with no idle bit between frames and the shifter-empty flag stays low.
- R7: A holding write (wr_addr=0) in the same cycle as the tick that starts or ends a stop bit sends the new character exactly once, and no extra characters appear.
- R8: A holding write clears the holding-empty flag from the next cycle. A holding write while a character is already waiting replaces it, and only the last value is sent.
- R9: A control write during a frame leaves that frame's bit timing and bit values unchanged.
- R10: The shifter-empty flag falls together with a start bit that follows an idle line. It rises only after a stop bit ends with no character to send.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = holding register, 1 = control fields |
| wr_data | input | DATA_W | Character, or control fields in bits 1:0 |
| baud_div | input | DIV_W | Divisor; bit period is baud_div+1 cycles |
| txd | output | 1 | Serial line, idles high |
| hre_flag | output | 1 | Holding register empty (interrupt source) |
| sre_flag | output | 1 | Shift register empty, no frame in progress |

## Verification
The bench builds the block with DATA_W=8, DIV_W=16 and the ninth-bit option on. It runs most traffic at a divisor of 3, which gives four-cycle bits, so a write can be placed on the exact tick that opens or closes a stop bit. It then switches to a divisor of 0, where every cycle is a tick. At that divisor the transfer points follow one another on consecutive cycles, and overwrites, queued characters and control writes fall right against the frame edges.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_NINTH,
    S_STOP
  } txq_state_e;

  typedef struct packed {
    logic nine_en;
    logic nine_val;
  } txq_cfg_t;

  localparam logic A_HOLD = 1'b0;
  localparam logic A_CFG  = 1'b1;

endpackage

// File: rtl/txq_baud.sv
module txq_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    if (tick) cnt_d = div;
    else      cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/txq_hold.sv
module txq_hold
  import txq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit NINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output txq_cfg_t          cfg
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              wr_hold;

  assign wr_hold = wr_en && (wr_addr == A_HOLD);

  // A write in the same cycle as a take wins: the old value leaves, the new one stays.
  always_comb begin
    full_d = full_q;
    dat_d  = dat_q;
    if (take) full_d = 1'b0;
    if (wr_hold) begin
      full_d = 1'b1;
      dat_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      full_q <= full_d;
      dat_q  <= dat_d;
    end
  end

  assign full = full_q;
  assign data = dat_q;

  generate
    if (NINE_EN) begin : g_cfg
      txq_cfg_t cfg_q, cfg_d;

      always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (wr_addr == A_CFG)) begin
          cfg_d.nine_en  = wr_data[0];
          cfg_d.nine_val = wr_data[1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
      end

      assign cfg = cfg_q;
    end else begin : g_nocfg
      assign cfg = '0;
    end
  endgenerate

endmodule

// File: rtl/txq_shift.sv
module txq_shift
  import txq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hfull,
  input  logic [DATA_W-1:0] hdata,
  input  txq_cfg_t          cfg,
  output logic              take,
  output logic              txd,
  output logic              idle
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  txq_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  n_q, n_d;
  txq_cfg_t          fr_q, fr_d;
  logic              pend_q, pend_d;
  logic              txd_q, txd_d;
  logic              to_stop, load;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    n_d     = n_q;
    fr_d    = fr_q;
    pend_d  = pend_q;
    txd_d   = txd_q;
    to_stop = 1'b0;
    load    = 1'b0;
    if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (hfull) begin
            load  = 1'b1;
            st_d  = S_START;
            txd_d = 1'b0;
          end
        end
        S_START: begin
          txd_d = sh_q[0];
          sh_d  = sh_q >> 1;
          n_d   = CNT_W'(1);
          st_d  = S_DATA;
        end
        S_DATA: begin
          if (n_q == CNT_W'(DATA_W)) begin
            if (fr_q.nine_en) begin
              txd_d = fr_q.nine_val;
              st_d  = S_NINTH;
            end else begin
              to_stop = 1'b1;
            end
          end else begin
            txd_d = sh_q[0];
            sh_d  = sh_q >> 1;
            n_d   = n_q + CNT_W'(1);
          end
        end
        S_NINTH: to_stop = 1'b1;
        S_STOP: begin
          if (pend_q) begin
            pend_d = 1'b0;
            st_d   = S_START;
            txd_d  = 1'b0;
          end else if (hfull) begin
            load  = 1'b1;
            st_d  = S_START;
            txd_d = 1'b0;
          end else begin
            st_d = S_IDLE;
          end
        end
        default: st_d = S_IDLE;
      endcase
      // Stop bit entry: data bits are spent, so the shifter can accept the waiting character.
      if (to_stop) begin
        st_d  = S_STOP;
        txd_d = 1'b1;
        if (hfull) begin
          load   = 1'b1;
          pend_d = 1'b1;
        end
      end
      if (load) begin
        sh_d = hdata;
        fr_d = cfg;
      end
    end
  end

  assign take = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      n_q    <= '0;
      fr_q   <= '0;
      pend_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      n_q    <= n_d;
      fr_q   <= fr_d;
      pend_q <= pend_d;
      txd_q  <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign idle = (st_q == S_IDLE);

endmodule

// File: rtl/txq_uart.sv
module txq_uart
  import txq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 16,
  parameter bit NINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  baud_div,
  output logic              txd,
  output logic              hre_flag,
  output logic              sre_flag
);

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              baud_tick;
  logic              h_full, h_take;
  logic [DATA_W-1:0] h_data;
  txq_cfg_t          h_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  txq_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_int_n),
    .div  (baud_div),
    .tick (baud_tick)
  );

  txq_hold #(.DATA_W(DATA_W), .NINE_EN(NINE_EN)) u_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .take   (h_take),
    .full   (h_full),
    .data   (h_data),
    .cfg    (h_cfg)
  );

  txq_shift #(.DATA_W(DATA_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (baud_tick),
    .hfull(h_full),
    .hdata(h_data),
    .cfg  (h_cfg),
    .take (h_take),
    .txd  (txd),
    .idle (sre_flag)
  );

  assign hre_flag = !h_full;

endmodule

// File: rtl/txq_uart_chk.sv
module txq_uart_chk
  import txq_pkg::*;
(
  input logic clk,
  input logic rst_ni,
  input logic tick,
  input logic wr_en,
  input logic wr_addr,
  input logic txd,
  input logic hre,
  input logic sre
);

  // R2: the line moves only in the cycle after a baud tick
  a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(txd) |-> $past(tick));

  // R2: an idle shifter leaves the line high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_ni)
    sre |-> txd);

  // R4: a waiting character on an idle line launches on the tick
  a_r4_idle_launch: assert property (@(posedge clk) disable iff (!rst_ni)
    (sre && !hre && tick) |=> (!sre && !txd));

  // R5: the holding register empties only while a frame is on the line
  a_r5_flag_in_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(hre) |-> !sre);

  // R8: a holding write clears the empty flag
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (wr_addr == A_HOLD)) |=> !hre);

  // R10: leaving idle always begins with a start bit
  a_r10_busy_with_start: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(sre) |-> !txd);

endmodule

bind txq_uart txq_uart_chk u_chk (
  .clk    (clk),
  .rst_ni (rst_int_n),
  .tick   (baud_tick),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .txd    (txd),
  .hre    (hre_flag),
  .sre    (sre_flag)
);

// File: tb/sim_txq_uart.sv
module sim_txq_uart;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] baud_div = CW'(3);
  logic          txd, hre, sre;

  always #10 clk = ~clk;

  txq_uart #(.DATA_W(DW), .DIV_W(CW), .NINE_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .baud_div(baud_div),
    .txd(txd), .hre_flag(hre), .sre_flag(sre)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int            rel;
  int            mcnt;
  bit            mfull;
  logic [DW-1:0] mhold;
  bit            mm9, mb9;
  bit            etxd = 1'b1;
  bit            ebusy = 1'b0;
  bit            lineq[$];
  int            sentq[$];

  function automatic void push_frame();
    lineq.push_back(1'b0);
    for (int i = 0; i < DW; i++) lineq.push_back(mhold[i]);
    if (mm9) lineq.push_back(mb9);
    lineq.push_back(1'b1);
    sentq.push_back(int'(mhold) | (mm9 ? (int'(mb9) << DW) : 0));
    mfull = 1'b0;
  endfunction

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      rel = 0; mcnt = 0; mfull = 1'b0; mhold = '0; mm9 = 1'b0; mb9 = 1'b0;
      etxd = 1'b1; ebusy = 1'b0; lineq.delete();
    end else if (rel < 2) begin
      rel++;
    end else begin
      tk = (mcnt == 0);
      mcnt = tk ? int'(baud_div) : mcnt - 1;
      if (tk) begin
        if (lineq.size() > 0) begin
          etxd = lineq.pop_front();
          ebusy = 1'b1;
          if (lineq.size() == 0 && mfull) push_frame();
        end else if (mfull) begin
          push_frame();
          etxd = lineq.pop_front();
          ebusy = 1'b1;
        end else begin
          etxd = 1'b1;
          ebusy = 1'b0;
        end
      end
      if (wr_en) begin
        if (wr_addr == 1'b0) begin
          mhold = wr_data;
          mfull = 1'b1;
        end else begin
          mm9 = wr_data[0];
          mb9 = wr_data[1];
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd === etxd, "R2 line per cycle", int'(txd), int'(etxd));
      chk(hre === !mfull, "R5 holding-empty flag", int'(hre), int'(!mfull));
      chk(sre === !ebusy, "R10 shifter-empty flag", int'(sre), int'(!ebusy));
    end
  end

  // ---------------- line decoder ----------------
  bit dbusy = 1'b0;
  bit dec9 = 1'b0;
  int dcyc, dval, dcount = 0;

  always @(negedge clk) begin
    int p, idx, nb, expv;
    if (!rst_n) begin
      dbusy = 1'b0;
    end else begin
      p = int'(baud_div) + 1;
      if (!dbusy) begin
        if (txd == 1'b0) begin
          dbusy = 1'b1; dcyc = 0; dval = 0;
        end
      end else begin
        dcyc++;
      end
      if (dbusy && (dcyc % p) == p / 2) begin
        idx = dcyc / p;
        nb = DW + (dec9 ? 1 : 0);
        if (idx >= 1 && idx <= nb) dval |= int'(txd) << (idx - 1);
        if (idx == nb + 1) begin
          chk(txd == 1'b1, {cur_tag, " stop bit"}, int'(txd), 1);
          expv = (sentq.size() > 0) ? sentq.pop_front() : -1;
          chk(dval == expv, {cur_tag, " decoded character"}, dval, expv);
          dcount++;
          dbusy = 1'b0;
        end
      end
    end
  end

  // gap monitor for back-to-back frames
  bit gapmon = 1'b0;
  int gap = 0;
  always @(negedge clk) if (gapmon && sre) gap++;

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input bit a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Holding write on the tick that enters the stop bit (left=1) or ends it (left=0).
  task automatic race(input int left, input int d);
    do @(negedge clk); while (!(mcnt == 0 && ebusy && lineq.size() == left));
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_hre();
    while (!hre) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(sre && hre && !dbusy));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int base;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 line in reset", int'(txd), 1);
    chk(hre == 1'b1, "R1 hre in reset", int'(hre), 1);
    chk(sre == 1'b1, "R1 sre in reset", int'(sre), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1 && hre && sre, "R1 after release", int'({txd, hre, sre}), 7);

    // R2 / R4: single character from idle
    cur_tag = "R2";
    wr(1'b0, 'hA5);
    chk(sre == 1'b1, "R4 still idle before tick", int'(sre), 1);
    while (sre) @(negedge clk);
    chk(txd == 1'b0, "R4 start bit with launch", int'(txd), 0);
    chk(hre == 1'b1, "R4 holding empty after launch", int'(hre), 1);
    wait_idle();

    // R5 / R6: three back-to-back characters
    cur_tag = "R6";
    base = dcount;
    wr(1'b0, 'h3C);
    while (sre) @(negedge clk);
    gapmon = 1'b1; gap = 0;
    wr(1'b0, 'h81);
    chk(hre == 1'b0, "R8 flag cleared by write", int'(hre), 0);
    wait_hre();
    chk(txd == 1'b1, "R5 flag rises with stop bit", int'(txd), 1);
    wr(1'b0, 'h5A);
    while (dcount < base + 3) @(negedge clk);
    gapmon = 1'b0;
    chk(gap == 0, "R6 no idle cycle between frames", gap, 0);
    wait_idle();

    // R8: overwrite of a waiting character
    cur_tag = "R8";
    base = dcount;
    wr(1'b0, 'h11);
    wait_hre();
    wr(1'b0, 'h22);
    wr(1'b0, 'h33);
    wait_idle();
    chk(dcount - base == 2, "R8 overwritten character not sent", dcount - base, 2);

    // R7: writes on the stop-bit ticks
    cur_tag = "R7";
    base = dcount;
    wr(1'b0, 'h40);
    wait_hre();
    race(1, 'hC3);
    race(0, 'h7E);
    race(0, 'h00);
    race(1, 'h5F);
    wait_idle();
    chk(dcount - base == 5, "R7 exactly one copy per write", dcount - base, 5);

    // R3: nine-bit frames, ninth bit taken at transfer
    cur_tag = "R3";
    dec9 = 1'b1;
    wr(1'b1, 'b11);
    wr(1'b0, 'h0F);
    wait_hre();
    wr(1'b1, 'b01);
    wr(1'b0, 'hF0);
    wait_idle();

    // R9: control writes inside a frame
    cur_tag = "R9";
    wr(1'b1, 'b11);
    wr(1'b0, 'h96);
    while (sre) @(negedge clk);
    for (int k = 0; k < 6; k++) wr(1'b1, (k % 2 == 0) ? 'b01 : 'b11);
    wait_idle();
    wr(1'b1, 'b00);
    dec9 = 1'b0;
    repeat (2) @(negedge clk);

    // R7 at divisor 0: every cycle is a tick
    cur_tag = "R7";
    baud_div = '0;
    base = dcount;
    wr(1'b0, 'h55);
    wait_hre();
    race(1, 'hAA);
    race(0, 'h01);
    race(0, 'h80);
    wait_idle();
    chk(dcount - base == 4, "R7 count at divisor 0", dcount - base, 4);

    chk(sentq.size() == 0, "R7 nothing left undelivered", sentq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule